// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block turns single read and write requests from an on-chip port into the strobe sequences that an external asynchronous static RAM needs. The RAM has 16-bit words, a 16-bit address and one active-low enable per byte lane. Each request carries an address, write data and a two-bit lane mask. The controller drives chip select, write enable, output enable and the lane enables, all active low. It also drives the data bus as an output value plus a drive-enable, and the pad tristate sits outside this block. Every phase length is a whole number of clock cycles. Each count is derived from a nanosecond figure and the clock period, so one code base covers both a fast and a slow memory grade.

Writes hold output enable high for the whole access. The controller turns its data drivers on only after write enable has been low for a cycle, and keeps them on through the cycle in which write enable returns high. The address and lane enables never move while write enable is low. A read keeps output enable low for the full address access time. It then captures the bus, clears the lanes that were not requested, and returns the word with a one-cycle strobe. After every access there is at least one full cycle with both chip select and output enable high before the next access starts.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset and between accesses, chip select, write enable, output enable and both lane enables are high, the data drive-enable is off, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low in every cycle in which chip select is low.
- R3: Lane-mask bit 0 selects data bits 7:0 and drives `sram_lane_n[0]` low. Bit 1 selects bits 15:8 and drives `sram_lane_n[1]` low. The enables stay at the inverted mask for the whole access.
- R4: A write changes only the lanes whose mask bit is 1. A write with mask 00 leaves the stored word unchanged.
- R5: Write enable stays low for at least `ceil(T_WP_NS/CLK_NS)` consecutive cycles (13 at the defaults).
- R6: The data drive-enable rises only in a cycle where write enable was already low in the previous cycle. It is still on in the cycle in which write enable returns high. The write data is driven for at least `ceil(T_DW_NS/CLK_NS)` cycles (8) before write enable rises.
- R7: For a write, chip select stays low for at least `ceil(T_WC_NS/CLK_NS)` cycles (19).
- R8: While write enable is low, the address, the lane enables and chip select do not change.
- R9: Output enable is high in every cycle of a write access, and the drive-enable is never on while output enable is low.
- R10: For a read, chip select and output enable stay low with write enable high for at least `ceil(T_AA_NS/CLK_NS)` cycles (19) before the bus is captured.
- R11: Each read gives exactly one single-cycle `rsp_valid` pulse, in request order. `rsp_rdata` holds the stored bytes on the requested lanes and zero on the others.
- R12: Between the last cycle with output enable low and the next cycle with chip select low, there are at least two cycles with output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| sram_addr | output | 16 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lane_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| sram_dq_out | output | 16 | Value for the data pads |
| sram_dq_drive | output | 1 | Pad drive enable |
| sram_dq_in | input | 16 | Value seen on the data pads |

## Verification
The bench models the memory so that a lane is stored only from data that was driven while write enable was low. A controller with a short write pulse, a short data setup or a missing hold-cycle drive therefore either stores stale bytes or trips the measured pulse and setup counts. Masked writes and masked reads, including mask 00, are read back. A design that ignores a mask bit would overwrite a neighbouring byte or return a nonzero unrequested lane, because the model puts 0xFF on lanes that were not enabled. A read followed at once by a write checks the turnaround gap: a design that drops the idle cycle starts the next access straight after output enable rises. The lowest and highest addresses are exercised so that a truncated address would alias.

// File: rtl/sramc_pkg.sv
// Shared types and helpers for the SRAM access controller.
// Assumes all timing figures are positive integers in nanoseconds.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_DONE
    } sramc_state_e;

    // Whole clock cycles covering a nanosecond figure (ceiling division).
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
// Down-counter that times one controller phase.
// A load sets the remaining count; expired is high once the count is zero.
// Assumes the owner loads (phase cycles - 1) on the edge that enters a phase.
module sramc_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_lane_merge.sv
// Clears the byte lanes of a captured word that were not requested.
// Assumes lane g occupies bits [g*LANE_W +: LANE_W].
module sramc_lane_merge #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic [LANES*LANE_W-1:0] bus_in,
    input  logic [LANES-1:0]        lane_mask,
    output logic [LANES*LANE_W-1:0] masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = lane_mask[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sramc_ctrl.sv
// Asynchronous SRAM access controller with byte-lane masking.
// Takes one request at a time over a valid/ready port. Writes use a setup
// cycle, a write-enable pulse and a hold/recovery phase, all with output
// enable high. Reads hold output enable low for the address access time and
// return the masked word with a one-cycle strobe. All memory strobes come
// straight from flops. Assumes the pad tristate is built outside this block.
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LANE_W  = 8,
    parameter int LANES   = 2,
    parameter int CLK_NS  = 8,
    parameter int T_WC_NS = 150,
    parameter int T_WP_NS = 100,
    parameter int T_DW_NS = 60,
    parameter int T_AA_NS = 150,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [LANES-1:0]  sram_lane_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_drive,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int WP_CYC    = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int DW_CYC    = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int AA_CYC    = ns_to_cyc(T_AA_NS, CLK_NS);
    // Pulse must cover the width and the setup after the one undriven cycle.
    localparam int PULSE_CYC = max_int(WP_CYC, DW_CYC + 1);
    // Hold phase stretches the access to the full write cycle.
    localparam int HOLD_CYC  = max_int(1, WC_CYC - PULSE_CYC - 1);
    localparam int CNT_W     = $clog2(max_int(max_int(PULSE_CYC, HOLD_CYC), AA_CYC) + 1);

    sramc_state_e      state_q, state_n;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic [LANES-1:0]  mask_q, mask_next;
    logic              access_n;
    logic [DATA_W-1:0] rd_masked;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sramc_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .bus_in    (sram_dq_in),
        .lane_mask (mask_q),
        .masked    (rd_masked)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RD_DONE);
    assign accept    = req_valid && req_ready;
    assign mask_next = accept ? req_mask : mask_q;
    assign access_n  = state_n inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_RD_ACCESS};

    // Next-state decode and phase timer loads.
    always_comb begin
        state_n  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_n = ST_WR_SETUP;
                    end else begin
                        state_n  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(AA_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                state_n  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_n  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WR_HOLD:   if (tmr_expired) state_n = ST_IDLE;
            ST_RD_ACCESS: if (tmr_expired) state_n = ST_RD_DONE;
            ST_RD_DONE:   state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Latch address, write data and mask when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
            mask_q      <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
            mask_q      <= req_mask;
        end
    end

    // Registered memory strobes decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_cs_n     <= 1'b1;
            sram_we_n     <= 1'b1;
            sram_oe_n     <= 1'b1;
            sram_lane_n   <= '1;
            sram_dq_drive <= 1'b0;
        end else begin
            sram_cs_n     <= !access_n;
            sram_we_n     <= (state_n != ST_WR_PULSE);
            sram_oe_n     <= (state_n != ST_RD_ACCESS);
            sram_lane_n   <= access_n ? ~mask_next : '1;
            sram_dq_drive <= ((state_n == ST_WR_PULSE) && (state_q == ST_WR_PULSE))
                             || (state_n == ST_WR_HOLD);
        end
    end

    // Capture the masked read word at the end of the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if ((state_q == ST_RD_ACCESS) && tmr_expired) begin
            rsp_rdata <= rd_masked;
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] we_low_cnt;

    // Counts consecutive cycles with write enable low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  we_low_cnt <= '0;
        else if (sram_we_n)          we_low_cnt <= '0;
        else if (we_low_cnt != '1)   we_low_cnt <= we_low_cnt + 1'b1;
    end

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= CNT_W'(WP_CYC)));

    assert_drive_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_drive) |-> (!sram_we_n && $past(!sram_we_n)));

    assert_drive_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_drive);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |->
            ($stable(sram_addr) && $stable(sram_lane_n) && !sram_cs_n));

    assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n || sram_dq_drive) |-> sram_oe_n);

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> !req_ready);

    assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sramc_ctrl_tb.sv
// Scoreboard bench: the driver pushes expected read words, the monitor pops
// and compares them, and a memory model commits only driven write data.
module sramc_ctrl_tb;

    localparam int CLK_NS = 8;
    localparam int WC = (150 + CLK_NS - 1) / CLK_NS;
    localparam int WP = (100 + CLK_NS - 1) / CLK_NS;
    localparam int DW = (60 + CLK_NS - 1) / CLK_NS;
    localparam int AA = (150 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_lane_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_drive;
    logic [15:0] sram_dq_in = '0;

    sramc_ctrl #(.CLK_NS(CLK_NS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
        .sram_dq_out(sram_dq_out), .sram_dq_drive(sram_dq_drive),
        .sram_dq_in(sram_dq_in)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] sram_mem [int];
    logic [15:0] ref_mem  [int];
    logic [15:0] exp_q [$];
    bit          cur_wr = 1'b0;
    logic [1:0]  cur_mask = 2'b00;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] seed_word(input int a);
        return 16'((a * 937) ^ 'hA5C3);
    endfunction

    function automatic logic [15:0] sram_rd(input int a);
        return sram_mem.exists(a) ? sram_mem[a] : seed_word(a);
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
    endfunction

    // Driver: called at a negedge, returns at the negedge after acceptance.
    task automatic do_req(input bit wr, input logic [15:0] a,
                          input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        cur_wr = wr;
        cur_mask = m;
        w = ref_rd(int'(a));
        if (wr) begin
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
        end else begin
            exp_q.push_back({m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and memory model state.
    bit          p_cs = 1, p_we = 1, p_drive = 0, p_rsp = 0;
    int          cs_run = 0, oe_run = 0, we_run = 0, drv_run = 0, since_oe = 100;
    bit          ready_bad = 0, lane_bad = 0, oe_bad = 0, addr_bad = 0;
    logic [15:0] addr_at_fall = '0, wdata_seen = '0;

    always @(negedge clk) begin
        logic [15:0] w, got;
        if (rst_n) begin
            w = sram_rd(int'(sram_addr));
            sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n)
                ? {sram_lane_n[1] ? 8'hFF : w[15:8], sram_lane_n[0] ? 8'hFF : w[7:0]}
                : 16'hBEEF;

            if (!sram_cs_n && p_cs) begin
                chk(since_oe >= 2, "R12", "oe-high gap before access", since_oe, 2);
                cs_run = 0; oe_run = 0;
                ready_bad = 0; lane_bad = 0; oe_bad = 0;
            end
            if (!sram_cs_n) begin
                cs_run++;
                if (req_ready) ready_bad = 1;
                if (sram_lane_n != ~cur_mask) lane_bad = 1;
                if (cur_wr && !sram_oe_n) oe_bad = 1;
                if (!sram_oe_n && sram_we_n) oe_run++;
            end
            if (sram_dq_drive && !sram_oe_n) oe_bad = 1;
            since_oe = sram_oe_n ? since_oe + 1 : 0;

            if (sram_dq_drive && !p_drive)
                chk(!sram_we_n && !p_we, "R6", "drive rose before write enable low", {p_we, sram_we_n}, 0);

            if (!sram_we_n) begin
                if (p_we) begin
                    we_run = 0; drv_run = 0; addr_bad = 0; addr_at_fall = sram_addr;
                end
                we_run++;
                if (sram_dq_drive) begin
                    drv_run++;
                    wdata_seen = sram_dq_out;
                end else begin
                    drv_run = 0;
                end
                if (sram_addr != addr_at_fall || sram_cs_n) addr_bad = 1;
            end
            if (sram_we_n && !p_we) begin
                chk(we_run >= WP, "R5", "write pulse cycles", we_run, WP);
                chk(drv_run >= DW, "R6", "data setup cycles", drv_run, DW);
                chk(sram_dq_drive, "R6", "drive at write end", sram_dq_drive, 1);
                chk(!addr_bad, "R8", "address moved during write", addr_bad, 0);
                w = sram_rd(int'(sram_addr));
                if (!sram_lane_n[0]) w[7:0]  = wdata_seen[7:0];
                if (!sram_lane_n[1]) w[15:8] = wdata_seen[15:8];
                sram_mem[int'(sram_addr)] = w;
            end

            if (sram_cs_n && !p_cs) begin
                if (cur_wr) begin
                    chk(cs_run >= WC, "R7", "write cycle length", cs_run, WC);
                    chk(!oe_bad, "R9", "output enable during write", oe_bad, 0);
                end else begin
                    chk(oe_run >= AA, "R10", "read access cycles", oe_run, AA);
                end
                chk(!lane_bad, "R3", "lane enables vs mask", sram_lane_n, ~cur_mask);
                chk(!ready_bad, "R2", "ready during access", ready_bad, 0);
                chk(sram_we_n && sram_oe_n && sram_lane_n == 2'b11 && !sram_dq_drive,
                    "R1", "idle strobes after access",
                    {sram_we_n, sram_oe_n, sram_lane_n, sram_dq_drive}, 5'b11110);
            end

            if (rsp_valid) begin
                chk(!p_rsp, "R11", "strobe longer than one cycle", p_rsp, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected response", rsp_rdata, 0);
                end else begin
                    got = exp_q.pop_front();
                    chk(rsp_rdata == got, "R4 R11", "read data", rsp_rdata, got);
                end
            end

            p_cs = sram_cs_n; p_we = sram_we_n; p_drive = sram_dq_drive; p_rsp = rsp_valid;
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sram_cs_n && sram_we_n && sram_oe_n && sram_lane_n == 2'b11 && !sram_dq_drive,
            "R1", "strobes after reset", {sram_cs_n, sram_we_n, sram_oe_n, sram_lane_n, sram_dq_drive}, 6'b111110);
        chk(req_ready && !rsp_valid, "R1", "handshake after reset", {req_ready, rsp_valid}, 2'b10);

        do_req(1, 16'h0010, 16'h1234, 2'b11);   // R4 full word
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        do_req(1, 16'h0010, 16'hABCD, 2'b01);   // R3 R4 low lane only
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        do_req(1, 16'h0010, 16'h5566, 2'b10);   // R3 R4 high lane only
        do_req(0, 16'h0010, 16'h0000, 2'b01);   // R11 upper zero
        do_req(0, 16'h0010, 16'h0000, 2'b10);   // R11 lower zero
        do_req(1, 16'h0010, 16'hFFFF, 2'b00);   // R4 mask 00 changes nothing
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        do_req(0, 16'h0010, 16'h0000, 2'b00);   // R11 empty read gives zero
        // R12: read immediately followed by write
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        do_req(1, 16'h0021, 16'h0F0F, 2'b11);
        do_req(0, 16'h0021, 16'h0000, 2'b11);
        // Address extremes
        do_req(1, 16'h0000, 16'h1111, 2'b11);
        do_req(1, 16'hFFFF, 16'h2222, 2'b11);
        do_req(0, 16'h0000, 16'h0000, 2'b11);
        do_req(0, 16'hFFFF, 16'h0000, 2'b11);
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a;
            a = 16'((i * 4099) & 16'hFFFF);
            do_req(1, a, 16'(i * 7919 + 3), 2'((i % 3) + 1));
            do_req(0, a, 16'h0000, 2'((i % 4)));
        end

        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_drive && req_ready,
            "R1", "idle with no request", {sram_cs_n, sram_oe_n, sram_we_n, sram_dq_drive, req_ready}, 5'b11101);
        chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule